// File: doc/BRIEF.md
# Dual-Line Search Window Memory

This block holds the reference pixels of a square search window for a block matcher working on N×N blocks. The window is W×W pixels and is divided into N×N tiles. Storage is spread over 2N single-port pixel RAMs, so that one access can deliver two whole lines of N pixels each. Rows of even parity within a tile go to one group of N RAMs, and rows of odd parity go to the other group. Each successive pair of rows inside a group is rotated by two positions across that group's RAMs. With this placement, any single line, any two adjacent lines, and any diagonally staggered pair of lines can be read at once, wherever they start in the window.

A caller writes pixels one at a time by coordinate. To read, it gives a mode and the coordinate of the first pixel. One cycle later the block returns two N-pixel vectors, already put back into coordinate order, together with valid flags. A request that does not fit in the window, or that uses an undefined mode, is rejected and flagged. A read issued in the same cycle as a write is also rejected and flagged, because each RAM has a single port.

Top module: `sw_window_mem`

## Requirements
- R1: Mode 0 (row) returns pixels (x0+i, y0) for i = 0..N-1 on line 0, with element i at bits [i*PW +: PW]. Line 0 is flagged valid and line 1 is not, one cycle after the request. Only the N RAMs that hold the row are enabled.
- R2: Mode 1 (column) returns pixels (x0, y0+i) on line 0 with the same element order and timing as R1. Line 1 is not valid.
- R3: Mode 2 (row pair) returns row y0 on line 0 and row y0+1 on line 1, both starting at x0. Both lines are valid and all 2N RAMs are enabled.
- R4: Mode 3 (column pair) returns column x0 on line 0 and column x0+1 on line 1, both starting at y0. Both lines are valid.
- R5: Mode 4 (diagonal row pair) returns row y0 from x0 on line 0 and row y0+1 from x0+1 on line 1.
- R6: Mode 5 (diagonal column pair) returns column x0 from y0 on line 0 and column x0+1 from y0+1 on line 1.
- R7: A read is rejected when its last pixel lies outside the W×W window, or when its mode code is 6 or 7. A rejected read raises the error flag one cycle later, with both valid flags low.
- R8: A read requested in the same cycle as a write is rejected as in R7. The write still takes effect.
- R9: While reset is asserted, and after it is released, both valid flags and the error flag are low. They stay low until a read is requested.
- R10: A write stores its data at the given (x, y) coordinate. Any later read that covers that pixel returns the most recently written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write one pixel |
| wr_x_i | input | $clog2(W) | Write column |
| wr_y_i | input | $clog2(W) | Write row |
| wr_data_i | input | PW | Write pixel value |
| rd_en_i | input | 1 | Read request |
| rd_mode_i | input | 3 | Read mode, codes 0..5 |
| rd_x_i | input | $clog2(W) | Column of the first pixel |
| rd_y_i | input | $clog2(W) | Row of the first pixel |
| line0_o | output | N*PW | First line, element i at bits [i*PW +: PW] |
| line1_o | output | N*PW | Second line, same layout |
| line0_valid_o | output | 1 | Line 0 holds read data |
| line1_valid_o | output | 1 | Line 1 holds read data |
| rd_err_o | output | 1 | Previous read was rejected |

## Verification
A fault in the placement function or in the realignment crossbar corrupts data as soon as the next read returns. Such a fault swaps or duplicates pixels within a line in that read, one cycle after the request. Because the bench sweeps every mode from every start coordinate over a window filled with distinct values, any misplaced pixel is seen within that single sweep. A fault in the range or mode decoding shows at the ports in a different way: the valid and error flags disagree with the arithmetic fit test, again one cycle after the request.

// File: rtl/swm_pkg.sv
package swm_pkg;
  typedef enum logic [2:0] {
    RD_ROW   = 3'd0,
    RD_COL   = 3'd1,
    RD_ROW2  = 3'd2,
    RD_COL2  = 3'd3,
    RD_ROWD  = 3'd4,
    RD_COLD  = 3'd5
  } rd_mode_e;
endpackage

// File: rtl/swm_bank.sv
module swm_bank #(
  parameter int PW    = 8,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [PW-1:0] d_i,
  output logic [PW-1:0] q_o
);
  logic [PW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= d_i;
    else if (en_i) q_o <= mem[addr_i];
  end
endmodule

// File: rtl/swm_req_map.sv
module swm_req_map
  import swm_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 8,
  localparam int NB    = 2 * N,
  localparam int BW    = W / N,
  localparam int DEPTH = BW * BW * (N / 2),
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int RIW   = $clog2(NB),
  localparam int CW    = $clog2(W)
) (
  input  logic                    rd_en_i,
  input  logic [2:0]              rd_mode_i,
  input  logic [CW-1:0]           rd_x_i,
  input  logic [CW-1:0]           rd_y_i,
  input  logic                    wr_en_i,
  input  logic [CW-1:0]           wr_x_i,
  input  logic [CW-1:0]           wr_y_i,
  output logic [NB-1:0]           ram_en_o,
  output logic [NB-1:0]           ram_we_o,
  output logic [NB-1:0][AW-1:0]   ram_addr_o,
  output logic [1:0][N-1:0][RIW-1:0] slot_ram_o,
  output logic                    pair_o,
  output logic                    req_ok_o
);
  // bank = parity group * N + rotated column (two positions per row pair)
  function automatic logic [RIW-1:0] ram_of(input int x, input int y);
    int lx, ly;
    lx = x % N;
    ly = y % N;
    return RIW'((ly % 2) * N + (lx + 2 * (ly / 2)) % N);
  endfunction

  function automatic logic [AW-1:0] addr_of(input int x, input int y);
    return AW'(((y / N) * BW + (x / N)) * (N / 2) + (y % N) / 2);
  endfunction

  int   ax, ay, ox, oy, last_x, last_y;
  logic mode_ok;
  logic [1:0][N-1:0][AW-1:0] slot_addr;

  always_comb begin
    ax = 0; ay = 0; ox = 0; oy = 0;
    mode_ok = 1'b1;
    pair_o  = 1'b0;
    case (rd_mode_i)
      RD_ROW:  ax = 1;
      RD_COL:  ay = 1;
      RD_ROW2: begin ax = 1; oy = 1; pair_o = 1'b1; end
      RD_COL2: begin ay = 1; ox = 1; pair_o = 1'b1; end
      RD_ROWD: begin ax = 1; ox = 1; oy = 1; pair_o = 1'b1; end
      RD_COLD: begin ay = 1; ox = 1; oy = 1; pair_o = 1'b1; end
      default: mode_ok = 1'b0;
    endcase
    last_x = int'(rd_x_i) + (N - 1) * ax + ox;
    last_y = int'(rd_y_i) + (N - 1) * ay + oy;
    req_ok_o = rd_en_i && !wr_en_i && mode_ok && (last_x < W) && (last_y < W);

    for (int l = 0; l < 2; l++) begin
      for (int i = 0; i < N; i++) begin
        slot_ram_o[l][i] = ram_of(int'(rd_x_i) + l * ox + i * ax,
                                  int'(rd_y_i) + l * oy + i * ay);
        slot_addr[l][i]  = addr_of(int'(rd_x_i) + l * ox + i * ax,
                                   int'(rd_y_i) + l * oy + i * ay);
      end
    end

    ram_en_o   = '0;
    ram_we_o   = '0;
    ram_addr_o = '0;
    if (req_ok_o) begin
      for (int l = 0; l < 2; l++) begin
        for (int i = 0; i < N; i++) begin
          if (l == 0 || pair_o) begin
            ram_en_o[slot_ram_o[l][i]]   = 1'b1;
            ram_addr_o[slot_ram_o[l][i]] = slot_addr[l][i];
          end
        end
      end
    end
    if (wr_en_i && (int'(wr_x_i) < W) && (int'(wr_y_i) < W)) begin
      ram_we_o[ram_of(int'(wr_x_i), int'(wr_y_i))]   = 1'b1;
      ram_addr_o[ram_of(int'(wr_x_i), int'(wr_y_i))] = addr_of(int'(wr_x_i), int'(wr_y_i));
    end
  end
endmodule

// File: rtl/swm_realign.sv
module swm_realign #(
  parameter int N  = 4,
  parameter int PW = 8,
  localparam int NB  = 2 * N,
  localparam int RIW = $clog2(NB)
) (
  input  logic [NB-1:0][PW-1:0]      bank_q_i,
  input  logic [1:0][N-1:0][RIW-1:0] slot_ram_i,
  output logic [N*PW-1:0]            line0_o,
  output logic [N*PW-1:0]            line1_o
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    assign line0_o[i*PW +: PW] = bank_q_i[slot_ram_i[0][i]];
    assign line1_o[i*PW +: PW] = bank_q_i[slot_ram_i[1][i]];
  end
endmodule

// File: rtl/sw_window_mem.sv
module sw_window_mem #(
  parameter int N  = 4,
  parameter int W  = 8,
  parameter int PW = 8,
  localparam int NB    = 2 * N,
  localparam int BW    = W / N,
  localparam int DEPTH = BW * BW * (N / 2),
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int RIW   = $clog2(NB),
  localparam int CW    = $clog2(W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [CW-1:0]   wr_x_i,
  input  logic [CW-1:0]   wr_y_i,
  input  logic [PW-1:0]   wr_data_i,
  input  logic            rd_en_i,
  input  logic [2:0]      rd_mode_i,
  input  logic [CW-1:0]   rd_x_i,
  input  logic [CW-1:0]   rd_y_i,
  output logic [N*PW-1:0] line0_o,
  output logic [N*PW-1:0] line1_o,
  output logic            line0_valid_o,
  output logic            line1_valid_o,
  output logic            rd_err_o
);
  logic [NB-1:0]                ram_en, ram_we;
  logic [NB-1:0][AW-1:0]        ram_addr;
  logic [NB-1:0][PW-1:0]        bank_q;
  logic [1:0][N-1:0][RIW-1:0]   slot_ram, slot_q;
  logic                         pair, req_ok;

  swm_req_map #(.N(N), .W(W)) u_map (
    .rd_en_i   (rd_en_i),
    .rd_mode_i (rd_mode_i),
    .rd_x_i    (rd_x_i),
    .rd_y_i    (rd_y_i),
    .wr_en_i   (wr_en_i),
    .wr_x_i    (wr_x_i),
    .wr_y_i    (wr_y_i),
    .ram_en_o  (ram_en),
    .ram_we_o  (ram_we),
    .ram_addr_o(ram_addr),
    .slot_ram_o(slot_ram),
    .pair_o    (pair),
    .req_ok_o  (req_ok)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    swm_bank #(.PW(PW), .DEPTH(DEPTH), .AW(AW)) u_bank (
      .clk_i (clk_i),
      .en_i  (ram_en[b]),
      .we_i  (ram_we[b]),
      .addr_i(ram_addr[b]),
      .d_i   (wr_data_i),
      .q_o   (bank_q[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line0_valid_o <= 1'b0;
      line1_valid_o <= 1'b0;
      rd_err_o      <= 1'b0;
      slot_q        <= '0;
    end else begin
      line0_valid_o <= req_ok;
      line1_valid_o <= req_ok && pair;
      rd_err_o      <= rd_en_i && !req_ok;
      if (req_ok) slot_q <= slot_ram;
    end
  end

  swm_realign #(.N(N), .PW(PW)) u_realign (
    .bank_q_i  (bank_q),
    .slot_ram_i(slot_q),
    .line0_o   (line0_o),
    .line1_o   (line1_o)
  );
endmodule

// File: rtl/sw_window_mem_chk.sv
module sw_window_mem_chk #(
  parameter int N = 4,
  localparam int NB = 2 * N
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_en_i,
  input logic          wr_en_i,
  input logic [2:0]    rd_mode_i,
  input logic          req_ok,
  input logic [NB-1:0] ram_en,
  input logic [NB-1:0] ram_we,
  input logic          line0_valid_o,
  input logic          line1_valid_o,
  input logic          rd_err_o
);
  p_single_en_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ok && rd_mode_i < 3'd2) |-> $countones(ram_en) == N);

  p_pair_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ok && rd_mode_i >= 3'd2) |-> $countones(ram_en) == NB);

  p_valid_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ok |=> line0_valid_o);

  p_pair_flags_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line1_valid_o |-> line0_valid_o);

  p_err_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> !line0_valid_o && !line1_valid_o);

  p_wr_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && rd_en_i) |=> rd_err_o);

  p_one_we_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ram_we) && (wr_en_i || ram_we == '0));

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !line0_valid_o && !rd_err_o);
endmodule

bind sw_window_mem sw_window_mem_chk #(.N(N)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_en_i      (rd_en_i),
  .wr_en_i      (wr_en_i),
  .rd_mode_i    (rd_mode_i),
  .req_ok       (req_ok),
  .ram_en       (ram_en),
  .ram_we       (ram_we),
  .line0_valid_o(line0_valid_o),
  .line1_valid_o(line1_valid_o),
  .rd_err_o     (rd_err_o)
);

// File: tb/sw_window_mem_test.sv
module sw_window_mem_test;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int PW = 8;
  localparam int CW = $clog2(W);

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            wr_en_i = 1'b0;
  logic [CW-1:0]   wr_x_i = '0, wr_y_i = '0;
  logic [PW-1:0]   wr_data_i = '0;
  logic            rd_en_i = 1'b0;
  logic [2:0]      rd_mode_i = '0;
  logic [CW-1:0]   rd_x_i = '0, rd_y_i = '0;
  logic [N*PW-1:0] line0_o, line1_o;
  logic            line0_valid_o, line1_valid_o, rd_err_o;

  int errors = 0;
  int checks = 0;
  logic done = 1'b0;
  logic [PW-1:0] model [W][W];

  always #2 clk_i = ~clk_i;

  sw_window_mem #(.N(N), .W(W), .PW(PW)) uut (.*);

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int m);
    case (m)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic write_px(input int x, input int y, input int d);
    wr_en_i = 1'b1; wr_x_i = CW'(x); wr_y_i = CW'(y); wr_data_i = PW'(d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    model[y][x] = PW'(d);
  endtask

  task automatic read_chk(input int m, input int x0, input int y0, input string req);
    int ax, ay, ox, oy, lx, ly;
    logic pair, ok;
    ax = 0; ay = 0; ox = 0; oy = 0; pair = 1'b1; ok = 1'b1;
    case (m)
      0: begin ax = 1; pair = 1'b0; end
      1: begin ay = 1; pair = 1'b0; end
      2: begin ax = 1; oy = 1; end
      3: begin ay = 1; ox = 1; end
      4: begin ax = 1; ox = 1; oy = 1; end
      5: begin ay = 1; ox = 1; oy = 1; end
      default: ok = 1'b0;
    endcase
    lx = x0 + (N - 1) * ax + (pair ? ox : 0);
    ly = y0 + (N - 1) * ay + (pair ? oy : 0);
    if (lx >= W || ly >= W) ok = 1'b0;
    rd_en_i = 1'b1; rd_mode_i = 3'(m); rd_x_i = CW'(x0); rd_y_i = CW'(y0);
    @(negedge clk_i);
    rd_en_i = 1'b0;
    if (!ok) begin
      check(req, "err", int'(rd_err_o), 1);
      check(req, "valid0", int'(line0_valid_o), 0);
      check(req, "valid1", int'(line1_valid_o), 0);
    end else begin
      check(req, "err", int'(rd_err_o), 0);
      check(req, "valid0", int'(line0_valid_o), 1);
      check(req, "valid1", int'(line1_valid_o), int'(pair));
      for (int i = 0; i < N; i++) begin
        check(req, "line0", int'(line0_o[i*PW +: PW]),
              int'(model[y0 + i * ay][x0 + i * ax]));
        if (pair)
          check(req, "line1", int'(line1_o[i*PW +: PW]),
                int'(model[y0 + oy + i * ay][x0 + ox + i * ax]));
      end
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9: flags low during reset
    check("R9", "valid0 in reset", int'(line0_valid_o), 0);
    check("R9", "err in reset", int'(rd_err_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9", "valid0 after reset", int'(line0_valid_o), 0);
    check("R9", "valid1 after reset", int'(line1_valid_o), 0);
    check("R9", "err after reset", int'(rd_err_o), 0);

    // R10: fill with distinct values
    for (int y = 0; y < W; y++)
      for (int x = 0; x < W; x++)
        write_px(x, y, ((y * W + x) * 37 + 11) & 8'hFF);

    // R1..R7: every mode from every start point
    for (int m = 0; m < 8; m++)
      for (int y = 0; y < W; y++)
        for (int x = 0; x < W; x++)
          read_chk(m, x, y, tag_of(m));

    // R8: read together with write is rejected, write lands
    rd_en_i = 1'b1; rd_mode_i = 3'd0; rd_x_i = 3'd2; rd_y_i = 3'd5;
    wr_en_i = 1'b1; wr_x_i = 3'd3; wr_y_i = 3'd5; wr_data_i = 8'h5A;
    @(negedge clk_i);
    rd_en_i = 1'b0; wr_en_i = 1'b0;
    model[5][3] = 8'h5A;
    check("R8", "err", int'(rd_err_o), 1);
    check("R8", "valid0", int'(line0_valid_o), 0);
    read_chk(0, 2, 5, "R8");

    // R10: overwrite then read through column and diagonal pair
    write_px(6, 1, 8'hC3);
    write_px(7, 2, 8'h3C);
    read_chk(1, 6, 0, "R10");
    read_chk(5, 6, 1, "R10");
    read_chk(4, 3, 1, "R10");

    // R9: idle cycle after reads keeps flags low
    @(negedge clk_i);
    check("R9", "idle valid0", int'(line0_valid_o), 0);
    check("R9", "idle err", int'(rd_err_o), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule